// File: doc/BRIEF.md
# Smart Card Clock and ETU Timer

This block derives the contact clock for a smart card from a fast system clock and produces the bit timing of the card's serial line. The system clock runs at twice the highest card clock frequency. A divider code of 1, 2, 4 or 8 sets the card clock to a 50 % duty square wave whose period is twice that code in system cycles. The elementary time unit (ETU), the length of one bit on the card line, is F/D card clock cycles. Here F is the clock rate conversion integer and D is the baud rate adjustment factor. The block counts this in system cycles as floor(2·div·F/D), and the count is worked out once, when a configuration is written.

A configuration write carries a divider code, F and D together. Each of the three must belong to its legal set, or the whole write is refused and a rejected flag is raised. An accepted write waits while the serial transmitter reports that a character is in flight. It takes effect in the first cycle the transmitter is idle. At that point the card clock and the ETU count both start again from zero. A one-cycle tick marks each ETU boundary, and a second strobe marks the middle of each ETU so the receiver can sample there.

Top module: `card_etu_timer`

## Requirements
- R1: After reset the timer runs with divider 8, F = 372 and D = 1, so the ETU is 5952 system cycles. The card clock, tick, mid-bit strobe and rejected flag are all low during reset.
- R2: With divider code N, the card clock is low for N system cycles and then high for N system cycles, starting low right after reset or after a new configuration takes effect.
- R3: etu_tick is high for one cycle every L = floor(2·N·F/D) system cycles. The first pulse comes L cycles after reset or after a configuration takes effect.
- R4: etu_half is high for one cycle at floor(L/2) cycles into every ETU.
- R5: A write whose divider code is not 1, 2, 4 or 8 is rejected and the active timing is left unchanged.
- R6: A write whose F is not one of 372, 558, 744, 1116, 1488, 1860, 512, 768, 1024, 1536 or 2048 is rejected and the active timing is left unchanged.
- R7: A write whose D is not one of 1, 2, 4, 8, 16, 32, 64, 12 or 20 is rejected and the active timing is left unchanged.
- R8: From the cycle after a write, cfg_rej is 1 if that write was rejected and 0 if it was accepted. cfg_rej keeps its value between writes.
- R9: An accepted write takes effect at the first clock edge after the write edge at which tx_busy is low. It never takes effect while tx_busy is high.
- R10: A later accepted write replaces a waiting one. A rejected write leaves a waiting one intact.
- R11: When a configuration takes effect, the card clock phase and the ETU count restart from zero, even if the new values equal the old ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the highest card clock frequency |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | One-cycle configuration write strobe |
| cfg_div | input | 4 | Card clock divider code |
| cfg_f | input | 12 | Clock rate conversion integer F |
| cfg_d | input | 7 | Baud rate adjustment factor D |
| tx_busy | input | 1 | High while a character is being transmitted |
| card_clk | output | 1 | Card contact clock |
| etu_tick | output | 1 | One-cycle pulse at each ETU boundary |
| etu_half | output | 1 | One-cycle pulse at the middle of each ETU |
| cfg_rej | output | 1 | Result of the most recent configuration write |

## Verification
The rate path is tried with the reset default and with four accepted writes, one on each axis. One write pairs the largest D with divider 1, giving the shortest ETU. One uses a power-of-two F. One uses D = 12, which divides exactly. One uses D = 20 with F = 558, where the quotient is truncated. Together these separate a wrong product, a wrong divisor and wrong rounding.

Three writes are rejected, one for each illegal field, and they show that each legality check stands alone. Writes made while the transmitter is busy, and a sequence of valid, invalid and valid writes in a row, separate deferred application from immediate application and show how the waiting slot is replaced. A rewrite of the current settings in the middle of an ETU shows whether the counters restart.

// File: rtl/cet_pkg.sv
package cet_pkg;
  localparam int DIV_W = 4;
  localparam int F_W   = 12;
  localparam int D_W   = 7;
  localparam int LEN_W = F_W + DIV_W + 1;

  localparam int DEF_DIV = 8;
  localparam int DEF_F   = 372;
  localparam int DEF_D   = 1;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [LEN_W-1:0] last;
    logic [LEN_W-1:0] mid;
  } rate_t;

  function automatic logic div_legal(input logic [DIV_W-1:0] v);
    return (v == DIV_W'(1)) || (v == DIV_W'(2)) || (v == DIV_W'(4)) || (v == DIV_W'(8));
  endfunction

  function automatic logic f_legal(input logic [F_W-1:0] v);
    case (v)
      F_W'(372), F_W'(558), F_W'(744), F_W'(1116), F_W'(1488), F_W'(1860),
      F_W'(512), F_W'(768), F_W'(1024), F_W'(1536), F_W'(2048): return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic d_legal(input logic [D_W-1:0] v);
    case (v)
      D_W'(1), D_W'(2), D_W'(4), D_W'(8), D_W'(16), D_W'(32), D_W'(64),
      D_W'(12), D_W'(20): return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic rate_t make_rate(input logic [DIV_W-1:0] dv,
                                      input logic [F_W-1:0] f,
                                      input logic [D_W-1:0] d);
    logic [LEN_W-1:0] num, den, len;
    rate_t r;
    num = (LEN_W'(dv) * LEN_W'(f)) << 1;
    den = (d == '0) ? LEN_W'(1) : LEN_W'(d);
    len = num / den;
    r.div  = dv;
    r.last = len - LEN_W'(1);
    r.mid  = (len >> 1) - LEN_W'(1);
    return r;
  endfunction
endpackage

// File: rtl/cet_cfg.sv
module cet_cfg
  import cet_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [F_W-1:0]   cfg_f,
  input  logic [D_W-1:0]   cfg_d,
  input  logic             tx_busy,
  output rate_t            cur,
  output logic             apply,
  output logic             rej
);
  localparam rate_t DEF_RATE = make_rate(DIV_W'(DEF_DIV), F_W'(DEF_F), D_W'(DEF_D));

  rate_t pend_rate;
  logic  pend_q;
  logic  legal;
  rate_t req_rate;

  assign legal    = div_legal(cfg_div) && f_legal(cfg_f) && d_legal(cfg_d);
  assign req_rate = make_rate(cfg_div, cfg_f, cfg_d);
  assign apply    = pend_q && !tx_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur       <= DEF_RATE;
      pend_rate <= DEF_RATE;
      pend_q    <= 1'b0;
      rej       <= 1'b0;
    end else begin
      if (apply) begin
        cur    <= pend_rate;
        pend_q <= 1'b0;
      end
      if (cfg_wr) begin
        if (legal) begin
          pend_rate <= req_rate;
          pend_q    <= 1'b1;
          rej       <= 1'b0;
        end else begin
          rej <= 1'b1;
        end
      end
    end
  end

  p_rej_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> $stable(rej));
  p_defer_busy_r9: assert property (@(posedge clk) disable iff (rst)
    tx_busy |=> $stable(cur));
  p_bad_write_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !div_legal(cfg_div)) |=> rej);
endmodule

// File: rtl/cet_clkgen.sv
module cet_clkgen
  import cet_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             card_clk
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap = (cnt == div - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt      <= '0;
      card_clk <= 1'b0;
    end else if (wrap) begin
      cnt      <= '0;
      card_clk <= ~card_clk;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  p_phase_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!restart && !wrap) |=> $stable(card_clk));
  p_div_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot(div));
endmodule

// File: rtl/cet_etu.sv
module cet_etu
  import cet_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [LEN_W-1:0] last,
  input  logic [LEN_W-1:0] mid,
  output logic             tick,
  output logic             half
);
  logic [LEN_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt  <= '0;
      tick <= 1'b0;
      half <= 1'b0;
    end else begin
      tick <= (cnt == last);
      half <= (cnt == mid);
      cnt  <= (cnt == last) ? '0 : cnt + LEN_W'(1);
    end
  end

  p_tick_half_apart_r4: assert property (@(posedge clk) disable iff (rst)
    !(tick && half));
  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= last);
  p_restart_clears_r11: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0) && !tick);
endmodule

// File: rtl/card_etu_timer.sv
module card_etu_timer
  import cet_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [F_W-1:0]   cfg_f,
  input  logic [D_W-1:0]   cfg_d,
  input  logic             tx_busy,
  output logic             card_clk,
  output logic             etu_tick,
  output logic             etu_half,
  output logic             cfg_rej
);
  rate_t cur;
  logic  apply;

  cet_cfg u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_div(cfg_div),
    .cfg_f(cfg_f), .cfg_d(cfg_d), .tx_busy(tx_busy),
    .cur(cur), .apply(apply), .rej(cfg_rej)
  );

  cet_clkgen u_clkgen (
    .clk(clk), .rst(rst), .restart(apply), .div(cur.div), .card_clk(card_clk)
  );

  cet_etu u_etu (
    .clk(clk), .rst(rst), .restart(apply), .last(cur.last), .mid(cur.mid),
    .tick(etu_tick), .half(etu_half)
  );
endmodule

// File: tb/test_card_etu_timer.sv
module test_card_etu_timer;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_div = 4'd0;
  logic [11:0] cfg_f = 12'd0;
  logic [6:0]  cfg_d = 7'd0;
  logic        tx_busy = 1'b0;
  logic        card_clk, etu_tick, etu_half, cfg_rej;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  string phase = "R1 defaults";

  card_etu_timer i_card_etu_timer (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_div(cfg_div), .cfg_f(cfg_f),
    .cfg_d(cfg_d), .tx_busy(tx_busy), .card_clk(card_clk),
    .etu_tick(etu_tick), .etu_half(etu_half), .cfg_rej(cfg_rej)
  );

  always #(CLK_P/2) clk = ~clk;

  // reference model state
  int m_div, m_len, m_pdiv, m_plen, m_t;
  bit m_pend, m_rej;

  function automatic bit ok_div(int v);
    return v == 1 || v == 2 || v == 4 || v == 8;
  endfunction
  function automatic bit ok_f(int v);
    int legal_f[11] = '{372, 558, 744, 1116, 1488, 1860, 512, 768, 1024, 1536, 2048};
    foreach (legal_f[i]) if (legal_f[i] == v) return 1;
    return 0;
  endfunction
  function automatic bit ok_d(int v);
    int legal_d[9] = '{1, 2, 4, 8, 16, 32, 64, 12, 20};
    foreach (legal_d[i]) if (legal_d[i] == v) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_div = 8; m_len = 5952; m_pend = 0; m_rej = 0; m_t = 0;
    end else begin
      if (m_pend && !tx_busy) begin
        m_div = m_pdiv; m_len = m_plen; m_pend = 0; m_t = 0;
      end else begin
        m_t++;
      end
      if (cfg_wr) begin
        if (ok_div(int'(cfg_div)) && ok_f(int'(cfg_f)) && ok_d(int'(cfg_d))) begin
          m_pdiv = int'(cfg_div);
          m_plen = (2 * int'(cfg_div) * int'(cfg_f)) / int'(cfg_d);
          m_pend = 1; m_rej = 0;
        end else begin
          m_rej = 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      int e_clk, e_tick, e_half;
      e_clk  = (m_t / m_div) % 2;
      e_tick = (m_t > 0 && m_t % m_len == 0) ? 1 : 0;
      e_half = (m_t > 0 && m_t % m_len == m_len / 2) ? 1 : 0;
      check(card_clk === 1'(e_clk),  {phase, " R2 card_clk"}, card_clk, e_clk);
      check(etu_tick === 1'(e_tick), {phase, " R3 etu_tick"}, etu_tick, e_tick);
      check(etu_half === 1'(e_half), {phase, " R4 etu_half"}, etu_half, e_half);
      check(cfg_rej === m_rej,       {phase, " R8 cfg_rej"},  cfg_rej, m_rej);
    end
  end

  task automatic write_cfg(input int dv, input int f, input int d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_div = 4'(dv); cfg_f = 12'(f); cfg_d = 7'(d);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P*190000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(card_clk === 1'b0, "R1 reset card_clk", card_clk, 0);
    check(etu_tick === 1'b0, "R1 reset etu_tick", etu_tick, 0);
    check(etu_half === 1'b0, "R1 reset etu_half", etu_half, 0);
    check(cfg_rej === 1'b0,  "R1 reset cfg_rej",  cfg_rej, 0);
    rst = 1'b0;
    phase = "R1 defaults";
    idle(12000);

    phase = "R3 F372 D64 div1";
    write_cfg(1, 372, 64);   idle(100);
    phase = "R2 F512 D32 div2";
    write_cfg(2, 512, 32);   idle(300);
    phase = "R3 F372 D12 div4";
    write_cfg(4, 372, 12);   idle(600);
    phase = "R3 F558 D20 div2 truncated";
    write_cfg(2, 558, 20);   idle(300);

    phase = "R5 bad divider";
    write_cfg(3, 372, 1);
    check(cfg_rej === 1'b1, "R5 divider 3 rejected", cfg_rej, 1);
    idle(250);
    phase = "R6 bad F";
    write_cfg(1, 400, 1);
    check(cfg_rej === 1'b1, "R6 F 400 rejected", cfg_rej, 1);
    idle(250);
    phase = "R7 bad D";
    write_cfg(1, 372, 3);
    check(cfg_rej === 1'b1, "R7 D 3 rejected", cfg_rej, 1);
    idle(250);
    phase = "R8 accepted clears flag";
    write_cfg(1, 372, 64);
    check(cfg_rej === 1'b0, "R8 accepted write clears flag", cfg_rej, 0);
    idle(100);

    phase = "R9 deferred while busy";
    @(negedge clk); tx_busy = 1'b1;
    write_cfg(2, 512, 32);
    idle(200);
    tx_busy = 1'b0;
    idle(300);

    phase = "R10 replace pending";
    @(negedge clk); tx_busy = 1'b1;
    write_cfg(1, 372, 64);
    write_cfg(5, 372, 64);
    write_cfg(4, 372, 12);
    write_cfg(8, 999, 1);
    idle(50);
    tx_busy = 1'b0;
    idle(700);

    phase = "R11 restart mid ETU";
    idle(100);
    write_cfg(4, 372, 12);
    idle(600);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule